// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a bus-mapped watchdog. Software sets a reload value, then sets an enable bit. The enable loads a 32-bit down-counter, which then counts one step per clock. To keep the counter from running out, software must write two fixed key words, in order, to a service location. The second key reloads the counter. If the counter reaches zero, a one-clock expiry pulse goes to the reset logic of the system, and the counter then waits at zero.

Two control bits can pause the count: one while a debug-halt input is high, and one while a low-power-stop input is high. A reload value below a floor of 0x100 is raised to the floor when it is loaded. The count can be read back, but the readable copy follows the counter only while the watchdog is disabled. While the watchdog is enabled, the copy keeps the last value it captured.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the control word reads 0, the reload register reads 0x0001_0000, the count view reads 0 and `expire_o` is low.
- R2: Register offsets: control at 0x00, reload at 0x08, service at 0x10 and count view at 0x14. Control bit 0 is enable, bit 1 is debug-freeze and bit 2 is low-power-stop. Bits 10:9 hold the service mode. All other control bits read 0, so the readable mask is 0x0000_0607. The service location and unmapped offsets read 0.
- R3: A control write that moves enable from 0 to 1 loads the counter from the reload register. On each following clock while enabled, the counter drops by 1.
- R4: A reload value below 0x100 is loaded as 0x100. This applies to both enable loads and service loads.
- R5: A service is a write of 0x0000_A602 to the service offset, followed by a write of 0x0000_B480 as the very next service write. A service completed while enabled, in mode 00, reloads the counter on the clock of the second write.
- R6: Any service write other than the expected next key clears the key tracker. If that write is 0x0000_A602, it starts a new sequence.
- R7: A service sequence written while the watchdog is disabled leaves the count unchanged.
- R8: When the service-mode field is not 00, a completed key sequence does not reload the counter.
- R9: With debug-freeze set and `dbg_halt_i` high, the counter holds its value. With debug-freeze clear, `dbg_halt_i` has no effect.
- R10: With low-power-stop set and `lp_stop_i` high, the counter holds its value.
- R11: When the counter steps from 1 to 0, `expire_o` is high for exactly one clock. This happens 256 clocks after a floor-clamped load. The counter then stays at 0.
- R12: Clearing enable holds the counter at its current value. The count view follows the counter (one clock late) only while disabled, and does not change while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per high clock |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| dbg_halt_i | input | 1 | Debug-halt indication |
| lp_stop_i | input | 1 | Low-power-stop indication |
| expire_o | output | 1 | One-clock pulse when the count reaches zero |

## Verification
The bench aims at the key tracker. It sends a correct pair, a pair broken by a stray word, and a repeated first key. A tracker that does not clear on a stray word would reload when it should not. A tracker that does not restart on a repeated first key would miss a valid service. Each count read is checked to the exact clock, using the clock numbers at which the writes happened, so an off-by-one load or decrement shows as a wrong value. The bench also times the expiry pulse from a clamped load: a missing floor would fire far too early, and a pulse held high would fail the width check. It further checks that pause inputs have no effect while their control bit is clear, and that the count view stays constant while enabled.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_TMO  = 'h08;
  localparam int unsigned OFS_SVC  = 'h10;
  localparam int unsigned OFS_CNT  = 'h14;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_DBGFRZ  = 1;
  localparam int unsigned BIT_LPSTOP  = 2;
  localparam int unsigned BIT_MODE_LO = 9;

  localparam logic [15:0] KEY_ARM  = 16'hA602;
  localparam logic [15:0] KEY_FIRE = 16'hB480;

  typedef struct packed {
    logic [1:0] mode;
    logic       lp_stop;
    logic       dbg_frz;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] TMO_RESET = 'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [DATA_W-1:0] cnt_live,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] tmo,
  output logic              en_rise,
  output logic              svc_wr,
  output logic [DATA_W-1:0] rdata
);
  logic sel_ctrl, sel_tmo, sel_svc, sel_cnt;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] tmo_q, tmo_d;
  logic [DATA_W-1:0] view_q;
  logic              view_ce;

  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_tmo  = (addr == ADDR_W'(OFS_TMO));
  assign sel_svc  = (addr == ADDR_W'(OFS_SVC));
  assign sel_cnt  = (addr == ADDR_W'(OFS_CNT));

  always_comb begin
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    if (we && sel_ctrl) begin
      ctrl_d.en      = wdata[BIT_EN];
      ctrl_d.dbg_frz = wdata[BIT_DBGFRZ];
      ctrl_d.lp_stop = wdata[BIT_LPSTOP];
      ctrl_d.mode    = wdata[BIT_MODE_LO+1:BIT_MODE_LO];
    end
    if (we && sel_tmo) tmo_d = wdata;
  end

  assign en_rise = we && sel_ctrl && wdata[BIT_EN] && !ctrl_q.en;
  assign svc_wr  = we && sel_svc;
  assign view_ce = !ctrl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= TMO_RESET;
    end else begin
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       view_q <= '0;
    else if (view_ce) view_q <= cnt_live;
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[BIT_EN]                      = ctrl_q.en;
      rdata[BIT_DBGFRZ]                  = ctrl_q.dbg_frz;
      rdata[BIT_LPSTOP]                  = ctrl_q.lp_stop;
      rdata[BIT_MODE_LO+1:BIT_MODE_LO]   = ctrl_q.mode;
    end else if (sel_tmo) begin
      rdata = tmo_q;
    end else if (sel_cnt) begin
      rdata = view_q;
    end
  end

  assign ctrl = ctrl_q;
  assign tmo  = tmo_q;
endmodule

// File: rtl/wdg_keyseq.sv
`timescale 1ns/1ps
module wdg_keyseq
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              seq_done
);
  localparam logic [DATA_W-1:0] WORD_ARM  = DATA_W'(KEY_ARM);
  localparam logic [DATA_W-1:0] WORD_FIRE = DATA_W'(KEY_FIRE);

  logic armed_q, armed_d;

  always_comb begin
    armed_d  = armed_q;
    seq_done = 1'b0;
    if (svc_wr) begin
      if (armed_q && (wdata == WORD_FIRE)) begin
        seq_done = 1'b1;
        armed_d  = 1'b0;
      end else begin
        armed_d  = (wdata == WORD_ARM);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdg_downcnt.sv
`timescale 1ns/1ps
module wdg_downcnt #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] FLOOR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, cnt_d, load_eff;
  logic              exp_q, exp_d;

  assign load_eff = (load_val < FLOOR) ? FLOOR : load_val;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      cnt_d = load_eff;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE;
      exp_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt    = cnt_q;
  assign expire = exp_q;
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] TMO_RESET = 'h0001_0000,
  parameter logic [DATA_W-1:0] FLOOR     = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt_i,
  input  logic              lp_stop_i,
  output logic              expire_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  ctrl_t             ctrl;
  logic [DATA_W-1:0] tmo, cnt;
  logic              en_rise, svc_wr, seq_done;
  logic              ctrl_en, ctrl_dbg, ctrl_lp, mode_fixed;
  logic              svc_reload, load, run;

  assign ctrl_en    = ctrl.en;
  assign ctrl_dbg   = ctrl.dbg_frz;
  assign ctrl_lp    = ctrl.lp_stop;
  assign mode_fixed = (ctrl.mode == 2'b00);

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_RESET(TMO_RESET)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .cnt_live(cnt), .ctrl(ctrl), .tmo(tmo),
    .en_rise(en_rise), .svc_wr(svc_wr), .rdata(bus_rdata)
  );

  wdg_keyseq #(.DATA_W(DATA_W)) u_keys (
    .clk(clk), .rst_n(rst_sync_n), .svc_wr(svc_wr),
    .wdata(bus_wdata), .seq_done(seq_done)
  );

  assign svc_reload = seq_done && ctrl_en && mode_fixed;
  assign load       = en_rise || svc_reload;
  assign run        = ctrl_en && !(ctrl_dbg && dbg_halt_i) && !(ctrl_lp && lp_stop_i);

  wdg_downcnt #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .load_val(tmo),
    .run(run), .cnt(cnt), .expire(expire_o)
  );
endmodule

// File: rtl/wdg_checker.sv
`timescale 1ns/1ps
module wdg_checker #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] FLOOR = 'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              dbg_frz,
  input logic              lp_stop,
  input logic              dbg_halt,
  input logic              lp_in,
  input logic              load,
  input logic [DATA_W-1:0] cnt,
  input logic              expire
);
  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);                                                   // R11
  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (cnt == '0));                                               // R11
  AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt >= FLOOR));                                              // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));                                      // R12
  AST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));                                        // R3
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_frz && dbg_halt && !load) |=> $stable(cnt));                      // R9
  AST_LP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_stop && lp_in && !load) |=> $stable(cnt));                         // R10
endmodule

bind keyed_wdog wdg_checker #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(ctrl_en), .dbg_frz(ctrl_dbg),
  .lp_stop(ctrl_lp), .dbg_halt(dbg_halt_i), .lp_in(lp_stop_i),
  .load(load), .cnt(cnt), .expire(expire_o)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [7:0] A_CTRL = 8'h00, A_TMO = 8'h08, A_SVC = 8'h10, A_CNT = 8'h14;
  localparam logic [31:0] K1 = 32'h0000_A602, K2 = 32'h0000_B480;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we;
  logic [DW-1:0] bus_rdata;
  logic          dbg_halt_i, lp_stop_i, expire_o;
  int            checks = 0, errors = 0, cyc = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdog u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .dbg_halt_i(dbg_halt_i),
    .lp_stop_i(lp_stop_i), .expire_o(expire_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    edge_no = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_TMO, v);  chk("R1 reload", v, 32'h0001_0000);
    rd(A_CNT, v);  chk("R1 count", v, 32'h0);
    chk("R1 expire", {31'b0, expire_o}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v; int e;
    wr(A_CTRL, 32'hFFFF_FFFE, e); rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0000_0606);
    wr(A_CTRL, 32'h0, e);
    wr(A_TMO, 32'h0000_1234, e);  rd(A_TMO, v);  chk("R2 reload rw", v, 32'h0000_1234);
    rd(A_SVC, v);  chk("R2 service reads 0", v, 32'h0);
    rd(8'h04, v);  chk("R2 unmapped", v, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v, v2; int e0, e1;
    wr(A_TMO, 32'h400, e0);
    wr(A_CTRL, 32'h1, e0);
    idle(37);
    wr(A_CTRL, 32'h0, e1);
    rd(A_CNT, v);  chk("R3 decrement", v, 32'h400 - 32'(e1 - e0));
    idle(10);
    rd(A_CNT, v2); chk("R12 held when disabled", v2, v);
    wr(A_CTRL, 32'h1, e0);
    idle(20);
    rd(A_CNT, v2); chk("R12 view frozen while enabled", v2, v);
    wr(A_CTRL, 32'h0, e1);
  endtask

  task automatic t_floor_expire();
    logic [31:0] v; int e0, ex; bit seen;
    wr(A_TMO, 32'h10, e0);
    wr(A_CTRL, 32'h1, e0);
    seen = 1'b0; ex = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (expire_o) begin seen = 1'b1; ex = cyc; end
    end
    chk("R4 R11 expire after clamp", 32'(ex - e0), 32'd256);
    @(negedge clk);
    chk("R11 pulse width", {31'b0, expire_o}, 32'h0);
    idle(5);
    wr(A_CTRL, 32'h0, e0);
    rd(A_CNT, v); chk("R11 stays at zero", v, 32'h0);
  endtask

  task automatic t_service();
    logic [31:0] v; int e0, es, ed;
    wr(A_TMO, 32'h300, e0);
    wr(A_CTRL, 32'h1, e0);
    idle(20);
    wr(A_SVC, K1, es);
    wr(A_SVC, K2, es);
    idle(5);
    wr(A_CTRL, 32'h0, ed);
    rd(A_CNT, v); chk("R5 service reload", v, 32'h300 - 32'(ed - es));
  endtask

  task automatic t_bad_seq();
    logic [31:0] v; int e0, es, ed;
    wr(A_CTRL, 32'h1, e0);
    wr(A_SVC, K1, es);
    wr(A_SVC, 32'h0000_1234, es);
    wr(A_SVC, K2, es);
    wr(A_CTRL, 32'h0, ed);
    rd(A_CNT, v); chk("R6 stray word clears tracker", v, 32'h300 - 32'(ed - e0));
    wr(A_CTRL, 32'h1, e0);
    idle(8);
    wr(A_SVC, K1, es);
    wr(A_SVC, K1, es);
    wr(A_SVC, K2, es);
    wr(A_CTRL, 32'h0, ed);
    rd(A_CNT, v); chk("R6 repeated first key restarts", v, 32'h300 - 32'(ed - es));
  endtask

  task automatic t_disabled_svc();
    logic [31:0] v, v2; int e;
    rd(A_CNT, v);
    wr(A_SVC, K1, e);
    wr(A_SVC, K2, e);
    idle(3);
    rd(A_CNT, v2); chk("R7 service while disabled", v2, v);
  endtask

  task automatic t_mode();
    logic [31:0] v; int e0, es, ed;
    wr(A_CTRL, 32'h0000_0201, e0);
    wr(A_SVC, K1, es);
    wr(A_SVC, K2, es);
    wr(A_CTRL, 32'h0000_0200, ed);
    rd(A_CNT, v); chk("R8 mode 01 ignores keys", v, 32'h300 - 32'(ed - e0));
    wr(A_CTRL, 32'h0, ed);
  endtask

  task automatic t_pause();
    logic [31:0] v; int e0, ed;
    dbg_halt_i = 1'b1;
    wr(A_CTRL, 32'h3, e0); idle(30); wr(A_CTRL, 32'h2, ed);
    rd(A_CNT, v); chk("R9 debug freeze holds", v, 32'h300);
    wr(A_CTRL, 32'h1, e0); idle(30); wr(A_CTRL, 32'h0, ed);
    rd(A_CNT, v); chk("R9 halt ignored without freeze bit", v, 32'h300 - 32'(ed - e0));
    dbg_halt_i = 1'b0;
    lp_stop_i = 1'b1;
    wr(A_CTRL, 32'h5, e0); idle(30); wr(A_CTRL, 32'h4, ed);
    rd(A_CNT, v); chk("R10 low-power stop holds", v, 32'h300);
    lp_stop_i = 1'b0;
    wr(A_CTRL, 32'h0, ed);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    dbg_halt_i = 1'b0; lp_stop_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_count();
    t_floor_expire();
    t_service();
    t_bad_seq();
    t_disabled_svc();
    t_mode();
    t_pause();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule